// File: doc/BRIEF.md
# Lockable Flash Erase Control Register

This block is the command register of a flash memory controller. Software reaches it over a simple register bus. Each access is a single-cycle write strobe with an address and a 32-bit word, and read data is returned combinationally for the addressed register. The command register selects the operation: a programming enable, single-page or whole-array erase, the target page, a burst-write mode, a start trigger, two interrupt enables and a security-invert flag.

The register starts out locked. In that state every write to it is dropped. Writing two fixed 32-bit keys, in order, to a separate key register releases the lock, and software can lock the register again at any time. A bad key attempt disables unlocking until the next reset. When software asks for an accepted start, the block sends a one-cycle start pulse to an external erase engine. The block watches the engine's busy line and retires the start when busy falls. A start request with no erase selected is refused and recorded as a sequence error. A small status register holds the end-of-operation, sequence-error and operation-error flags, which software clears by writing 1 to them. The enabled flags drive two interrupt lines.

Address map: 0 is the command register, 1 is the status register, 2 is the key register (reads as 0). Command bits: PG bit 0, PER bit 1, MER bit 2, page number bits 9:3, BWR bit 14, STRT bit 16, EOP interrupt enable bit 24, error interrupt enable bit 25, INV bit 29, LOCK bit 31. All other bits read as 0. Status bits: busy 0 (live engine input), end-of-operation 1, sequence error 2, operation error 3. Keys: first 32'h4F1C_2D83, then 32'hB7E0_59A6.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset the command register reads 32'h8000_0000 (only LOCK set), the status register reads 0, and both interrupt lines are low.
- R2: While unlocked, a command write stores PG, PER, MER, the page number, BWR, both interrupt enables and INV at their stated bit positions, and the reserved bits read back as 0.
- R3: While LOCK is set, writes to the command register change none of its fields.
- R4: Writing the first key and then the second key to the key register while locked clears LOCK.
- R5: A key write with any other value, or the keys in the wrong order, leaves LOCK set, and after that no key sequence clears LOCK until reset.
- R6: Writing 1 to LOCK (bit 31) sets it, and writing 0 to it never clears it.
- R7: A start request (STRT=1 written while unlocked and no start pending) with PER or MER set makes STRT read 1 and pulses eng_start for exactly one cycle. During that pulse eng_page carries the page number and eng_mass carries MER.
- R8: A start request with both PER and MER clear leaves STRT at 0, gives no eng_start pulse, and sets the sequence-error status bit (bit 2).
- R9: STRT cannot be cleared by software. It clears, and end-of-operation (status bit 1) sets, on the clock edge after eng_busy is seen falling.
- R10: Writing 1 to a status flag bit (1, 2 or 3) clears it. Writing 0 leaves it unchanged.
- R11: irq_eop is high exactly when the EOP interrupt enable and end-of-operation are both set, and irq_err is high exactly when the error interrupt enable and operation-error are both set.
- R12: A cycle with eng_err high sets operation-error (status bit 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 command, 1 status, 2 key) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| eng_busy | input | 1 | Erase engine busy |
| eng_err | input | 1 | Erase engine operation error pulse |
| eng_start | output | 1 | One-cycle start pulse to the erase engine |
| eng_page | output | PNB_W | Page to erase |
| eng_mass | output | 1 | Whole-array erase selected |
| irq_eop | output | 1 | End-of-operation interrupt |
| irq_err | output | 1 | Operation-error interrupt |

## Verification
The bench targets the lock path. It writes while locked, which a design that failed to gate writes would accept. It sends the keys in reverse order and then the correct pair, which a design that did not remember a failed attempt would accept. It writes 0 to LOCK, which a design with a plain read-write lock bit would take as an unlock. It requests a start with no erase mode selected, which a careless design would pass to the engine without flagging an error. It also writes 0 to a pending STRT and later lowers busy, to catch a start bit that software can clear or that never retires. Finally it toggles the interrupt enables against set and clear flags, to catch interrupts that ignore their enable or track the wrong status bit.

// File: rtl/fec_pkg.sv
`timescale 1ns/1ps
package fec_pkg;

    localparam int DATA_W = 32;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h4F1C_2D83;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'hB7E0_59A6;

    // Command register bit positions
    localparam int B_PG    = 0;
    localparam int B_PER   = 1;
    localparam int B_MER   = 2;
    localparam int B_PNB   = 3;
    localparam int B_BWR   = 14;
    localparam int B_STRT  = 16;
    localparam int B_EOPIE = 24;
    localparam int B_ERRIE = 25;
    localparam int B_INV   = 29;
    localparam int B_LOCK  = 31;

    // Status register bit positions
    localparam int S_BSY = 0;
    localparam int S_EOP = 1;
    localparam int S_SEQ = 2;
    localparam int S_OPE = 3;

    // Register addresses
    localparam int REG_CTL = 0;
    localparam int REG_STS = 1;
    localparam int REG_KEY = 2;

    typedef struct packed {
        logic pg;
        logic per;
        logic mer;
        logic bwr;
        logic eopie;
        logic errie;
        logic inv;
    } ctl_flags_t;

    typedef struct packed {
        logic operr;
        logic seqerr;
        logic eop;
    } sts_flags_t;

    typedef enum logic [1:0] {
        KEY_WAIT_FIRST,
        KEY_WAIT_SECOND,
        KEY_REFUSED
    } key_state_t;

    function automatic ctl_flags_t decode_flags(input logic [DATA_W-1:0] w);
        ctl_flags_t f;
        f.pg    = w[B_PG];
        f.per   = w[B_PER];
        f.mer   = w[B_MER];
        f.bwr   = w[B_BWR];
        f.eopie = w[B_EOPIE];
        f.errie = w[B_ERRIE];
        f.inv   = w[B_INV];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] encode_flags(input ctl_flags_t f);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[B_PG]    = f.pg;
        w[B_PER]   = f.per;
        w[B_MER]   = f.mer;
        w[B_BWR]   = f.bwr;
        w[B_EOPIE] = f.eopie;
        w[B_ERRIE] = f.errie;
        w[B_INV]   = f.inv;
        return w;
    endfunction

    function automatic logic erase_selected(input ctl_flags_t f);
        return f.per | f.mer;
    endfunction

    // Write-one-to-clear update with set taking priority
    function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/fec_key_unlock.sv
`timescale 1ns/1ps
module fec_key_unlock
    import fec_pkg::*;
#(
    parameter logic [DATA_W-1:0] FIRST_KEY  = KEY_FIRST,
    parameter logic [DATA_W-1:0] SECOND_KEY = KEY_SECOND
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              locked,
    output logic              unlock
);

    key_state_t state_q;
    key_state_t state_d;

    always_comb begin
        state_d = state_q;
        unlock  = 1'b0;
        if (key_wr && locked) begin
            case (state_q)
                KEY_WAIT_FIRST: begin
                    state_d = (key_data == FIRST_KEY) ? KEY_WAIT_SECOND : KEY_REFUSED;
                end
                KEY_WAIT_SECOND: begin
                    if (key_data == SECOND_KEY) begin
                        state_d = KEY_WAIT_FIRST;
                        unlock  = 1'b1;
                    end else begin
                        state_d = KEY_REFUSED;
                    end
                end
                default: state_d = KEY_REFUSED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KEY_WAIT_FIRST;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/fec_ctrl_reg.sv
`timescale 1ns/1ps
module fec_ctrl_reg
    import fec_pkg::*;
#(
    parameter int PNB_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unlock,
    input  logic              busy_fall,
    output ctl_flags_t        flags,
    output logic [PNB_W-1:0]  pnb,
    output logic              strt,
    output logic              lock,
    output logic              start_pulse,
    output logic              seq_err_set
);

    ctl_flags_t wr_flags;
    logic       accept;
    logic       req_start;
    logic       good_start;

    always_comb begin
        wr_flags    = decode_flags(wdata);
        accept      = ctl_wr && !lock;
        req_start   = accept && wdata[B_STRT] && !strt;
        good_start  = req_start && erase_selected(wr_flags);
        seq_err_set = req_start && !erase_selected(wr_flags);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags       <= '0;
            pnb         <= '0;
            strt        <= 1'b0;
            lock        <= 1'b1;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= good_start;
            if (accept) begin
                flags <= wr_flags;
                pnb   <= wdata[B_PNB +: PNB_W];
            end
            if (good_start)     strt <= 1'b1;
            else if (busy_fall) strt <= 1'b0;
            if (accept && wdata[B_LOCK]) lock <= 1'b1;
            else if (unlock)             lock <= 1'b0;
        end
    end

endmodule

// File: rtl/fec_status.sv
`timescale 1ns/1ps
module fec_status
    import fec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              eng_busy,
    input  logic              eng_err,
    input  logic              seq_err_set,
    input  logic              sts_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eopie,
    input  logic              errie,
    output logic              busy_fall,
    output sts_flags_t        sts,
    output logic              irq_eop,
    output logic              irq_err
);

    logic busy_q;
    logic clr_eop, clr_seq, clr_ope;

    always_comb begin
        busy_fall = busy_q && !eng_busy;
        clr_eop   = sts_wr && wdata[S_EOP];
        clr_seq   = sts_wr && wdata[S_SEQ];
        clr_ope   = sts_wr && wdata[S_OPE];
        irq_eop   = eopie && sts.eop;
        irq_err   = errie && sts.operr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sts    <= '0;
        end else begin
            busy_q     <= eng_busy;
            sts.eop    <= w1c_next(sts.eop,    busy_fall,   clr_eop);
            sts.seqerr <= w1c_next(sts.seqerr, seq_err_set, clr_seq);
            sts.operr  <= w1c_next(sts.operr,  eng_err,     clr_ope);
        end
    end

endmodule

// File: rtl/flash_erase_ctl.sv
`timescale 1ns/1ps
module flash_erase_ctl
    import fec_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int PNB_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_err,
    output logic              eng_start,
    output logic [PNB_W-1:0]  eng_page,
    output logic              eng_mass,
    output logic              irq_eop,
    output logic              irq_err
);

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(REG_CTL);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(REG_STS);
    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(REG_KEY);

    ctl_flags_t        ctl_cfg;
    logic [PNB_W-1:0]  pnb_q;
    logic              strt_q;
    logic              lock_q;
    sts_flags_t        sts_q;
    logic              unlock;
    logic              busy_fall;
    logic              seq_err_set;
    logic              ctl_wr, sts_wr, key_wr;
    logic [31:0]       ctl_word;
    logic [31:0]       sts_word;

    always_comb begin
        ctl_wr = bus_wr && (bus_addr == A_CTL);
        sts_wr = bus_wr && (bus_addr == A_STS);
        key_wr = bus_wr && (bus_addr == A_KEY);
    end

    fec_key_unlock u_key (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_data (bus_wdata),
        .locked   (lock_q),
        .unlock   (unlock)
    );

    fec_ctrl_reg #(.PNB_W(PNB_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr      (ctl_wr),
        .wdata       (bus_wdata),
        .unlock      (unlock),
        .busy_fall   (busy_fall),
        .flags       (ctl_cfg),
        .pnb         (pnb_q),
        .strt        (strt_q),
        .lock        (lock_q),
        .start_pulse (eng_start),
        .seq_err_set (seq_err_set)
    );

    fec_status u_sts (
        .clk         (clk),
        .rst         (rst),
        .eng_busy    (eng_busy),
        .eng_err     (eng_err),
        .seq_err_set (seq_err_set),
        .sts_wr      (sts_wr),
        .wdata       (bus_wdata),
        .eopie       (ctl_cfg.eopie),
        .errie       (ctl_cfg.errie),
        .busy_fall   (busy_fall),
        .sts         (sts_q),
        .irq_eop     (irq_eop),
        .irq_err     (irq_err)
    );

    always_comb begin
        ctl_word                   = encode_flags(ctl_cfg);
        ctl_word[B_PNB +: PNB_W]   = pnb_q;
        ctl_word[B_STRT]           = strt_q;
        ctl_word[B_LOCK]           = lock_q;

        sts_word        = '0;
        sts_word[S_BSY] = eng_busy;
        sts_word[S_EOP] = sts_q.eop;
        sts_word[S_SEQ] = sts_q.seqerr;
        sts_word[S_OPE] = sts_q.operr;

        case (bus_addr)
            A_CTL:   bus_rdata = ctl_word;
            A_STS:   bus_rdata = sts_word;
            default: bus_rdata = '0;
        endcase
    end

    assign eng_page = pnb_q;
    assign eng_mass = ctl_cfg.mer;

endmodule

// File: rtl/fec_chk.sv
`timescale 1ns/1ps
module fec_chk
    import fec_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              eng_busy,
    input logic              eng_start,
    input logic              irq_eop,
    input ctl_flags_t        ctl_cfg,
    input logic              strt_q,
    input logic              lock_q,
    input sts_flags_t        sts_q
);

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(REG_CTL);
    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(REG_KEY);

    // R3
    locked_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_q && bus_wr && bus_addr == A_CTL) |=> $stable(ctl_cfg));

    // R4
    lock_release_key_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q) |-> $past(bus_wr && bus_addr == A_KEY && bus_wdata == KEY_SECOND));

    // R7
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R8
    seq_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!lock_q && !strt_q && bus_wr && bus_addr == A_CTL && bus_wdata[B_STRT]
         && !bus_wdata[B_PER] && !bus_wdata[B_MER]) |=> (!eng_start && sts_q.seqerr));

    // R9
    strt_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strt_q) |-> ($past(eng_busy, 2) && !$past(eng_busy)));

    // R11
    irq_eop_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_cfg.eopie && sts_q.eop) |-> irq_eop);

endmodule

bind flash_erase_ctl fec_chk #(.ADDR_W(ADDR_W)) u_fec_chk (.*);

// File: tb/flash_erase_ctl_bench.sv
`timescale 1ns/1ps
module flash_erase_ctl_bench;

    localparam int ADDR_W = 2;
    localparam int PNB_W  = 7;
    localparam logic [31:0] K1 = 32'h4F1C_2D83;
    localparam logic [31:0] K2 = 32'hB7E0_59A6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              eng_busy = 1'b0;
    logic              eng_err = 1'b0;
    logic              eng_start;
    logic [PNB_W-1:0]  eng_page;
    logic              eng_mass;
    logic              irq_eop;
    logic              irq_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // kinds: 0 read data, 1 irq_eop, 2 irq_err, 3 eng_start, 4 eng_page, 5 eng_mass
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sbq[$];

    flash_erase_ctl #(.ADDR_W(ADDR_W), .PNB_W(PNB_W)) u_flash_erase_ctl (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .eng_busy  (eng_busy),
        .eng_err   (eng_err),
        .eng_start (eng_start),
        .eng_page  (eng_page),
        .eng_mass  (eng_mass),
        .irq_eop   (irq_eop),
        .irq_err   (irq_err)
    );

    always #2 clk = ~clk;

    // Monitor: pops expected items and compares them against the outputs
    initial begin
        forever begin
            sb_item_t it;
            logic [31:0] act;
            wait (sbq.size() != 0);
            #0.1;
            it = sbq.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'd0, irq_eop};
                2:       act = {31'd0, irq_err};
                3:       act = {31'd0, eng_start};
                4:       act = 32'(eng_page);
                default: act = {31'd0, eng_mass};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int kind, input int addr, input logic [31:0] exp, input string tag);
        sb_item_t it;
        if (kind == 0) bus_addr = ADDR_W'(addr);
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sbq.push_back(it);
        #0.2;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        bus_addr  = ADDR_W'(addr);
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
    endtask

    task automatic finish_busy();
        eng_busy = 1'b1;
        tick();
        eng_busy = 1'b0;
        tick();
    endtask

    initial begin
        do_reset();

        // R1 reset state
        expect_item(0, 0, 32'h8000_0000, "R1 ctl reset");
        expect_item(0, 1, 32'h0, "R1 sts reset");
        expect_item(1, 0, 32'h0, "R1 irq_eop reset");
        expect_item(2, 0, 32'h0, "R1 irq_err reset");

        // R3 locked write ignored
        bus_write(0, 32'h0300_0002);
        expect_item(0, 0, 32'h8000_0000, "R3 locked write dropped");

        // R4 unlock
        bus_write(2, K1);
        bus_write(2, K2);
        expect_item(0, 0, 32'h0, "R4 unlock clears lock");

        // R2 field positions, reserved bits
        bus_write(0, 32'h7FFE_FFFF);
        expect_item(0, 0, 32'h2300_43FF, "R2 fields and reserved");
        bus_write(0, 32'h0);
        expect_item(0, 0, 32'h0, "R2 fields cleared");

        // R8 start with no erase mode
        bus_write(0, 32'h0001_0000);
        expect_item(3, 0, 32'h0, "R8 no start pulse");
        expect_item(0, 0, 32'h0, "R8 strt stays clear");
        expect_item(0, 1, 32'h4, "R8 seq error set");

        // R10 write-one-to-clear
        bus_write(1, 32'h0);
        expect_item(0, 1, 32'h4, "R10 write 0 keeps flag");
        bus_write(1, 32'h4);
        expect_item(0, 1, 32'h0, "R10 write 1 clears flag");

        // R7 page erase start
        bus_write(0, 32'h0101_02AA);
        expect_item(3, 0, 32'h1, "R7 start pulse");
        expect_item(4, 0, 32'h55, "R7 page number");
        expect_item(5, 0, 32'h0, "R7 mass low");
        expect_item(0, 0, 32'h0101_02AA, "R7 strt reads 1");
        tick();
        expect_item(3, 0, 32'h0, "R7 pulse one cycle");

        // R9 software cannot clear strt; busy fall clears it
        bus_write(0, 32'h0100_02AA);
        expect_item(0, 0, 32'h0101_02AA, "R9 strt not cleared by write");
        eng_busy = 1'b1;
        tick();
        expect_item(0, 1, 32'h1, "R9 busy visible");
        eng_busy = 1'b0;
        tick();
        expect_item(0, 0, 32'h0100_02AA, "R9 strt cleared on busy fall");
        expect_item(0, 1, 32'h2, "R9 eop set on busy fall");
        expect_item(1, 0, 32'h1, "R11 irq_eop with enable");

        // R11 enable gates interrupt
        bus_write(0, 32'h0000_02AA);
        expect_item(1, 0, 32'h0, "R11 irq_eop disabled");
        expect_item(0, 1, 32'h2, "R11 eop still held");
        bus_write(1, 32'h2);
        expect_item(0, 1, 32'h0, "R10 eop cleared");

        // R12 operation error
        eng_err = 1'b1;
        tick();
        eng_err = 1'b0;
        expect_item(0, 1, 32'h8, "R12 operr set");
        expect_item(2, 0, 32'h0, "R11 irq_err disabled");
        bus_write(0, 32'h0200_0000);
        expect_item(2, 0, 32'h1, "R11 irq_err enabled");

        // R7 mass erase
        bus_write(0, 32'h0001_0004);
        expect_item(3, 0, 32'h1, "R7 mass start pulse");
        expect_item(5, 0, 32'h1, "R7 mass selected");
        expect_item(2, 0, 32'h0, "R11 irq_err enable dropped");
        finish_busy();
        expect_item(0, 0, 32'h0000_0004, "R9 mass strt cleared");
        expect_item(0, 1, 32'hA, "R9 eop with operr");

        // R6 software lock, cannot be cleared
        bus_write(0, 32'h8000_0000);
        expect_item(0, 0, 32'h8000_0000, "R6 lock set");
        bus_write(0, 32'h0300_0006);
        expect_item(0, 0, 32'h8000_0000, "R6 write 0 keeps lock");

        // R5 wrong order, then correct pair refused
        bus_write(2, K2);
        bus_write(2, K1);
        expect_item(0, 0, 32'h8000_0000, "R5 wrong order stays locked");
        bus_write(2, K1);
        bus_write(2, K2);
        expect_item(0, 0, 32'h8000_0000, "R5 refused until reset");

        // R5 wrong value
        do_reset();
        bus_write(2, K1);
        bus_write(2, 32'h1234_5678);
        bus_write(2, K1);
        bus_write(2, K2);
        expect_item(0, 0, 32'h8000_0000, "R5 bad value stays locked");

        // R4 reset re-enables unlocking
        do_reset();
        bus_write(2, K1);
        bus_write(2, K2);
        expect_item(0, 0, 32'h0, "R4 unlock after reset");

        #1;
        wait (sbq.size() == 0);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule